// File: doc/BRIEF.md
# General Call Software Reset Detector

This block sits beside an I2C target's protocol engine and watches for the general-call software reset sequence. The engine hands it already-decoded bus events: a START (first or repeated), a STOP, and a completed 8-bit byte along with its value. From these events the detector decides whether the target should drive an acknowledge in the ninth clock of the byte that just arrived. When the sequence ends in a way that calls for it, the detector also raises a single-cycle reset request. The register bank and the protocol engine use that request to return to their power-up defaults.

The sequence the detector looks for is:

1. A START.
2. The general-call address byte with the read/write bit clear.
3. Exactly one command byte carrying the reset code.
4. A STOP.

Any step that fails drops the detector back to idle, and it stays idle until the next START. A repeated START in place of the final STOP cancels the reset. Any byte after the accepted reset code is refused. The detector never asks for a reset on its own initiative.

Top module: `gcr_detector`

## Requirements
- R1: While `rst` is high, or while `ext_rst_n` is low, both outputs are 0 from the next clock edge on. The detector is left idle, and a START presented while `ext_rst_n` is low is ignored.
- R2: After a START, a completed byte equal to 00h (general-call address, bit 0 = 0 for write) sets `ack_req` to 1 one cycle after `byte_done`. `ack_req` then holds until the next bus event, which clears it.
- R3: After a START, any other first byte is not acknowledged and the detector goes idle. This includes 01h (general call with bit 0 = 1, a read) and 40h.
- R4: After an acknowledged address, only the command byte 06h is acknowledged. Any other value is refused and the detector goes idle.
- R5: A byte that follows the acknowledged 06h is not acknowledged, and a later STOP then produces no reset.
- R6: A STOP that directly follows the acknowledged 06h makes `soft_rst` high for exactly one cycle, the cycle after the STOP is sampled. `ack_req` is 0 in that cycle.
- R7: A repeated START after the acknowledged 06h produces no reset. Instead it restarts recognition at the address byte.
- R8: Bytes and STOPs outside a valid sequence never produce an acknowledge or a reset. This covers bytes with no preceding START and STOPs in any state other than after an acknowledged 06h.
- R9: Pulling `ext_rst_n` low partway through a sequence discards that sequence, so a following STOP gives no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | External active-low reset; clears and holds the detector idle |
| start_in | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_in | input | 1 | One-cycle pulse: STOP seen |
| byte_done | input | 1 | One-cycle pulse: eight bits received |
| rx_byte | input | 8 | Value of the completed byte, valid with `byte_done` |
| ack_req | output | 1 | Request to drive ACK for the byte just completed |
| soft_rst | output | 1 | One-cycle software reset request |

## Verification
The bench drives directed sequences that differ from the valid one at exactly one step. These cover a read-flagged address, a foreign address, a wrong command code, an extra byte, a repeated START in place of the STOP, an external reset mid-sequence, and bytes or STOPs with no START. Each one separates a detector that tracks every step from one that only matches part of the pattern. A long run of random events follows. Its bytes are biased toward 00h, 01h and 06h so that partial sequences and back-to-back restarts occur often. Acknowledge and reset outputs are compared after every event and across idle gaps, so both the hold of `ack_req` and the single-cycle width of `soft_rst` are tested.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_CMD   = 2'd2,
        ST_ARMED = 2'd3
    } gcr_state_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_STOP  = 2'd2,
        EV_BYTE  = 2'd3
    } gcr_kind_e;

    typedef struct packed {
        gcr_kind_e          kind;
        logic [BYTE_W-1:0]  data;
    } gcr_event_t;

    typedef struct packed {
        logic accept;
        logic fire;
    } gcr_decision_t;

    function automatic logic byte_is(input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-1:0] ref_val);
        return b == ref_val;
    endfunction

endpackage

// File: rtl/gcr_event_sel.sv
module gcr_event_sel
    import gcr_pkg::*;
(
    input  logic               start_in,
    input  logic               stop_in,
    input  logic               byte_done,
    input  logic [BYTE_W-1:0]  rx_byte,
    output gcr_event_t         ev
);
    // STOP outranks START, START outranks a byte completion.
    always_comb begin
        ev.data = rx_byte;
        if (stop_in)        ev.kind = EV_STOP;
        else if (start_in)  ev.kind = EV_START;
        else if (byte_done) ev.kind = EV_BYTE;
        else                ev.kind = EV_NONE;
    end
endmodule

// File: rtl/gcr_seq_fsm.sv
module gcr_seq_fsm
    import gcr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] GC_ADDR   = 8'h00,
    parameter logic [BYTE_W-1:0] RESET_CMD = 8'h06
)(
    input  logic          clk,
    input  logic          clr,
    input  gcr_event_t    ev,
    output gcr_state_e    state,
    output gcr_decision_t dec
);
    gcr_state_e state_nxt;

    always_comb begin
        state_nxt  = state;
        dec.accept = 1'b0;
        dec.fire   = 1'b0;
        unique case (ev.kind)
            EV_STOP: begin
                dec.fire  = (state == ST_ARMED);
                state_nxt = ST_IDLE;
            end
            EV_START: state_nxt = ST_ADDR;
            EV_BYTE: begin
                unique case (state)
                    ST_ADDR: begin
                        dec.accept = byte_is(ev.data, GC_ADDR);
                        state_nxt  = dec.accept ? ST_CMD : ST_IDLE;
                    end
                    ST_CMD: begin
                        dec.accept = byte_is(ev.data, RESET_CMD);
                        state_nxt  = dec.accept ? ST_ARMED : ST_IDLE;
                    end
                    default: state_nxt = ST_IDLE;
                endcase
            end
            default: state_nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // R4
    armed_entry_chk: assert property (@(posedge clk) disable iff (clr)
        (state == ST_ARMED && $past(state) != ST_ARMED) |-> ($past(state) == ST_CMD));

    // R8
    cmd_entry_chk: assert property (@(posedge clk) disable iff (clr)
        (state == ST_CMD && $past(state) != ST_CMD) |-> ($past(state) == ST_ADDR));
endmodule

// File: rtl/gcr_out_regs.sv
module gcr_out_regs
    import gcr_pkg::*;
(
    input  logic          clk,
    input  logic          clr,
    input  gcr_event_t    ev,
    input  gcr_decision_t dec,
    output logic          ack_req,
    output logic          soft_rst
);
    always_ff @(posedge clk) begin
        if (clr) begin
            ack_req  <= 1'b0;
            soft_rst <= 1'b0;
        end else begin
            if (ev.kind != EV_NONE) ack_req <= dec.accept;
            soft_rst <= dec.fire;
        end
    end

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (clr)
        soft_rst |=> !soft_rst);

    // R6
    no_ack_with_rst_chk: assert property (@(posedge clk) disable iff (clr)
        !(soft_rst && ack_req));
endmodule

// File: rtl/gcr_detector.sv
module gcr_detector
    import gcr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] GC_ADDR   = 8'h00,
    parameter logic [BYTE_W-1:0] RESET_CMD = 8'h06
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    input  logic              start_in,
    input  logic              stop_in,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              ack_req,
    output logic              soft_rst
);
    logic          clr;
    gcr_event_t    ev;
    gcr_state_e    state;
    gcr_decision_t dec;

    assign clr = rst | ~ext_rst_n;

    gcr_event_sel u_sel (
        .start_in (start_in),
        .stop_in  (stop_in),
        .byte_done(byte_done),
        .rx_byte  (rx_byte),
        .ev       (ev)
    );

    gcr_seq_fsm #(.GC_ADDR(GC_ADDR), .RESET_CMD(RESET_CMD)) u_fsm (
        .clk  (clk),
        .clr  (clr),
        .ev   (ev),
        .state(state),
        .dec  (dec)
    );

    gcr_out_regs u_out (
        .clk     (clk),
        .clr     (clr),
        .ev      (ev),
        .dec     (dec),
        .ack_req (ack_req),
        .soft_rst(soft_rst)
    );

    // R1: clearing in one cycle forces both outputs low in the next
    logic prev_clr;
    always_ff @(posedge clk) begin
        prev_clr <= clr;
        if (prev_clr) begin
            clear_outputs_chk: assert (!ack_req && !soft_rst);
        end
    end

    // R6
    pulse_after_stop_chk: assert property (@(posedge clk) disable iff (clr)
        soft_rst |-> $past(stop_in));

    // R2
    ack_after_byte_chk: assert property (@(posedge clk) disable iff (clr)
        $rose(ack_req) |-> $past(byte_done));
endmodule

// File: tb/gcr_detector_bench.sv
module gcr_detector_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       start_in = 1'b0;
    logic       stop_in = 1'b0;
    logic       byte_done = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       ack_req;
    logic       soft_rst;

    always #2 clk = ~clk;

    gcr_detector u_gcr_detector (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n),
        .start_in(start_in), .stop_in(stop_in),
        .byte_done(byte_done), .rx_byte(rx_byte),
        .ack_req(ack_req), .soft_rst(soft_rst)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int m_st   = 0;   // 0 idle, 1 expecting address, 2 expecting command, 3 armed
    bit m_ack  = 0;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_accept(input int st, input logic [7:0] b);
        return (st == 1 && b == 8'h00) || (st == 2 && b == 8'h06);
    endfunction

    function automatic int exp_next(input int st, input bit acc);
        if (acc) return st + 1;
        return 0;
    endfunction

    task automatic do_start();
        @(negedge clk); start_in = 1'b1;
        @(negedge clk); start_in = 1'b0;
        m_st = 1; m_ack = 0;
        chk("R2 ack cleared by START", ack_req, 1'b0);
        chk("R7 no reset on START", soft_rst, 1'b0);
    endtask

    task automatic do_byte(input logic [7:0] b);
        bit acc;
        string tag;
        acc = exp_accept(m_st, b);
        case (m_st)
            1: tag = acc ? "R2 address ack" : "R3 address refused";
            2: tag = "R4 command byte";
            3: tag = "R5 extra byte";
            default: tag = "R8 byte while idle";
        endcase
        @(negedge clk); byte_done = 1'b1; rx_byte = b;
        @(negedge clk); byte_done = 1'b0;
        m_ack = acc;
        m_st = exp_next(m_st, acc);
        chk(tag, ack_req, acc);
        chk("R8 no reset on byte", soft_rst, 1'b0);
    endtask

    task automatic do_stop();
        bit fire;
        fire = (m_st == 3);
        @(negedge clk); stop_in = 1'b1;
        @(negedge clk); stop_in = 1'b0;
        m_st = 0; m_ack = 0;
        chk(fire ? "R6 reset pulse" : "R8 no reset on stray STOP", soft_rst, fire);
        chk("R6 ack low at STOP", ack_req, 1'b0);
        @(negedge clk);
        chk("R6 pulse one cycle", soft_rst, 1'b0);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R2 ack holds between events", ack_req, m_ack);
            chk("R8 no reset while idle", soft_rst, 1'b0);
        end
    endtask

    task automatic ext_reset_with_start();
        @(negedge clk); ext_rst_n = 1'b0; start_in = 1'b1;
        @(negedge clk); start_in = 1'b0;
        chk("R1 ack low under ext reset", ack_req, 1'b0);
        chk("R1 reset low under ext reset", soft_rst, 1'b0);
        @(negedge clk); ext_rst_n = 1'b1;
        m_st = 0; m_ack = 0;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1977));
        repeat (3) @(negedge clk);
        chk("R1 ack after rst", ack_req, 1'b0);
        chk("R1 reset after rst", soft_rst, 1'b0);
        rst = 1'b0;
        gap(2);

        do_byte(8'h00);                 // R8 byte without START
        do_stop();                      // R8 stray STOP

        do_start(); do_byte(8'h00); gap(3); do_byte(8'h06); gap(2); do_stop();   // R6

        do_start(); do_byte(8'h01); do_byte(8'h06); do_stop();   // R3 read flag
        do_start(); do_byte(8'h40); do_stop();                   // R3 foreign address
        do_start(); do_byte(8'h00); do_byte(8'h07); do_stop();   // R4 wrong command
        do_start(); do_byte(8'h00); do_byte(8'h06); do_byte(8'h06); do_stop();   // R5
        do_start(); do_byte(8'h00); do_byte(8'h06); do_start();  // R7 repeated START
        do_byte(8'h00); do_byte(8'h06); do_stop();               // R7 restart works

        do_start(); do_byte(8'h00); do_byte(8'h06);
        ext_reset_with_start();                                  // R9 and R1
        do_byte(8'h00);                                          // R1 START was ignored
        do_stop();                                               // R9 no reset

        for (int k = 0; k < 600; k++) begin
            int r;
            logic [7:0] b;
            r = int'($urandom_range(0, 9));
            if (r < 3) do_start();
            else if (r < 4) do_stop();
            else begin
                case ($urandom_range(0, 3))
                    0: b = 8'h00;
                    1: b = 8'h06;
                    2: b = 8'h01;
                    default: b = 8'($urandom);
                endcase
                do_byte(b);
            end
            gap(int'($urandom_range(0, 2)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule